// File: doc/BRIEF.md
# Bit Test and Modify Unit

This execution block handles the bit-test instruction family. It decodes the second opcode byte and the ModRM reg field into one of four operations: test, test-and-set, test-and-reset and test-and-complement. The block copies the selected bit of the original operand into the carry flag. It then produces the operand with that bit left alone, forced to 1, forced to 0 or inverted. The operand size is 16, 32 or 64 bits. The bit index comes from a register or from an immediate.

For register operands the whole operation runs inside the unit. For memory operands the unit issues a load on a request/acknowledge memory port. A modifying form then writes the new value back to the same address, and the test-only form stops after the load. A register bit offset on a memory operand is signed. The unit turns that offset into a byte address relative to the supplied base. The set, reset and complement masks come from one seed pattern (1, or all ones except bit 0) rotated left by the bit position within the operand width.

A caller presents a request while `req_ready` is high and waits for the one-cycle `done` pulse. The `result` and `flags_out` registers then hold the outcome until the next operation.

Top module: `bit_test_unit`

## Requirements
- R1: After reset `req_ready` is 1, and `done`, `undef_op`, `mem_req`, `flags_out` and `result` are all 0.
- R2: At completion, bit 0 of `flags_out` (the carry flag) equals the selected bit of the operand as it was before any change.
- R3: The modified value is unchanged for test (op 0), has the selected bit set for set (op 1), cleared for reset (op 2) and inverted for complement (op 3). No other bit changes, and the bits above the operand width are 0.
- R4: With register-supplied index, second opcode byte 0xA3 selects test, 0xAB set, 0xB3 reset and 0xBB complement.
- R5: Opcode 0xBA with ModRM reg 4, 5, 6 or 7 selects test, set, reset or complement with the immediate index. Reg values 0 to 3, and any opcode not listed in R4 or R5, raise `undef_op` together with `done` one cycle after acceptance. In that case there is no memory access and `flags_out` is loaded with `flags_in` unchanged.
- R6: For register operands, and for every immediate index, the bit position is the index modulo the width. `size_sel` encodes 0 = 16, 1 = 32, 2 or 3 = 64 bits.
- R7: For a memory operand with a register index, the index is a signed offset at the operand width. The address is `base_addr` plus (offset >>> log2(width)) times width/8, and the bit position is the offset modulo the width. With an immediate index the address is `base_addr`.
- R8: A modifying memory form performs exactly one load and then one store to the same address. The store data is the modified value. The test-only form performs one load and no store. A request stays high with a stable address until it is acknowledged.
- R9: `done` is a one-cycle pulse. It comes 2 cycles after acceptance for register forms, on the cycle after the load acknowledge for memory test, and on the cycle after the store acknowledge for memory modify forms.
- R10: Only the carry flag changes: `flags_out` bits above bit 0 equal `flags_in` as sampled at acceptance.
- R11: A request is accepted only while `req_ready` is high. A request presented while busy is ignored, with no effect on memory traffic or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| opc | input | 8 | Second opcode byte |
| modrm_reg | input | 3 | ModRM reg field |
| size_sel | input | 2 | Operand size: 0=16, 1=32, 2/3=64 |
| use_mem | input | 1 | Operand lives in memory |
| opnd_reg | input | 64 | Register operand value |
| idx_reg | input | 64 | Register bit index / signed bit offset |
| imm_idx | input | 6 | Low six bits of the immediate index |
| base_addr | input | AW | Memory operand base byte address |
| flags_in | input | FLAG_W | Flags before the operation, carry at bit 0 |
| flags_out | output | FLAG_W | Flags after the operation |
| result | output | 64 | Modified (or tested) operand value |
| done | output | 1 | Completion pulse |
| undef_op | output | 1 | Undefined opcode pulse, with done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Access size, same encoding as size_sel |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Load data, valid with mem_ack |
| mem_ack | input | 1 | Request acknowledge |

## Verification
A wrong latched bit position or size shows up at the first `done` pulse. It appears as a carry flag or modified bit that disagrees with a plain shift-and-mask model, or as nonzero bits above the operand width. A corrupt sequencer state shows at the memory port within a cycle or two: a store on a test-only access, a store to an address other than the load, or a request that changes while unacknowledged. It also shows as a `done` pulse on the wrong cycle, since the register, memory-test and memory-modify latencies are each fixed. A latched flag copy that goes wrong appears in the upper `flags_out` bits at completion.

// File: rtl/bit_test_unit.sv
module bit_test_unit #(
  parameter int AW = 32,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        opc,
  input  logic [2:0]        modrm_reg,
  input  logic [1:0]        size_sel,
  input  logic              use_mem,
  input  logic [63:0]       opnd_reg,
  input  logic [63:0]       idx_reg,
  input  logic [5:0]        imm_idx,
  input  logic [AW-1:0]     base_addr,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out,
  output logic [63:0]       result,
  output logic              done,
  output logic              undef_op,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ack
);

  localparam logic [1:0] OP_TEST = 2'd0;
  localparam logic [1:0] OP_RST  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_LOAD, S_STORE} state_t;

  state_t            state;
  logic [1:0]        op_q, sz_q;
  logic [5:0]        pos_q;
  logic [63:0]       opnd_q, res_q, wdat_q;
  logic [AW-1:0]     addr_q;
  logic [FLAG_W-1:0] flg_q, flg_out_q;
  logic              done_q, ud_q;

  logic              dec_ud, dec_imm;
  logic [1:0]        dec_op;

  always_comb begin
    dec_ud  = 1'b0;
    dec_imm = 1'b0;
    dec_op  = OP_TEST;
    case (opc)
      8'hA3: dec_op = 2'd0;
      8'hAB: dec_op = 2'd1;
      8'hB3: dec_op = 2'd2;
      8'hBB: dec_op = 2'd3;
      8'hBA: begin
        dec_imm = 1'b1;
        dec_op  = modrm_reg[1:0];
        dec_ud  = ~modrm_reg[2];
      end
      default: dec_ud = 1'b1;
    endcase
  end

  logic [63:0]        wm_in, wm;
  logic [5:0]         pm_in, pos_in;
  logic [2:0]         sh_in;
  logic signed [63:0] off_in, word_in;
  logic [AW-1:0]      addr_in;

  always_comb begin
    case (size_sel)
      2'd0: begin wm_in = 64'h0000_0000_0000_FFFF; pm_in = 6'd15; sh_in = 3'd4;
                  off_in = {{48{idx_reg[15]}}, idx_reg[15:0]}; end
      2'd1: begin wm_in = 64'h0000_0000_FFFF_FFFF; pm_in = 6'd31; sh_in = 3'd5;
                  off_in = {{32{idx_reg[31]}}, idx_reg[31:0]}; end
      default: begin wm_in = '1; pm_in = 6'd63; sh_in = 3'd6;
                  off_in = idx_reg; end
    endcase
    pos_in  = (dec_imm ? imm_idx : idx_reg[5:0]) & pm_in;
    word_in = off_in >>> sh_in;
    addr_in = (use_mem && !dec_imm) ? base_addr + AW'(word_in <<< (sh_in - 3'd3))
                                    : base_addr;
  end

  always_comb begin
    case (sz_q)
      2'd0:    wm = 64'h0000_0000_0000_FFFF;
      2'd1:    wm = 64'h0000_0000_FFFF_FFFF;
      default: wm = '1;
    endcase
  end

  logic [63:0] seedv, rmask, src, newv;
  logic [15:0] s16;
  logic [31:0] s32;
  logic        cf;

  assign seedv = ((op_q == OP_RST) ? ~64'd1 : 64'd1) & wm;
  assign s16   = seedv[15:0];
  assign s32   = seedv[31:0];

  always_comb begin
    case (sz_q)
      2'd0:    rmask = {48'd0, (s16 << pos_q[3:0]) | (s16 >> (5'd16 - {1'b0, pos_q[3:0]}))};
      2'd1:    rmask = {32'd0, (s32 << pos_q[4:0]) | (s32 >> (6'd32 - {1'b0, pos_q[4:0]}))};
      default: rmask = (seedv << pos_q) | (seedv >> (7'd64 - {1'b0, pos_q}));
    endcase
  end

  assign src = (state == S_EXEC) ? opnd_q : (mem_rdata & wm);
  assign cf  = src[pos_q];

  always_comb begin
    case (op_q)
      2'd0:    newv = src;
      2'd1:    newv = src | rmask;
      2'd2:    newv = src & rmask;
      default: newv = src ^ rmask;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= '0;
      sz_q      <= '0;
      pos_q     <= '0;
      opnd_q    <= '0;
      res_q     <= '0;
      wdat_q    <= '0;
      addr_q    <= '0;
      flg_q     <= '0;
      flg_out_q <= '0;
      done_q    <= 1'b0;
      ud_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ud_q   <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (dec_ud) begin
            done_q    <= 1'b1;
            ud_q      <= 1'b1;
            flg_out_q <= flags_in;
          end else begin
            op_q   <= dec_op;
            sz_q   <= size_sel;
            pos_q  <= pos_in;
            opnd_q <= opnd_reg & wm_in;
            flg_q  <= flags_in;
            addr_q <= addr_in;
            state  <= use_mem ? S_LOAD : S_EXEC;
          end
        end
        S_EXEC: begin
          res_q     <= newv;
          flg_out_q <= {flg_q[FLAG_W-1:1], cf};
          done_q    <= 1'b1;
          state     <= S_IDLE;
        end
        S_LOAD: if (mem_ack) begin
          res_q     <= newv;
          flg_out_q <= {flg_q[FLAG_W-1:1], cf};
          if (op_q == OP_TEST) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            wdat_q <= newv;
            state  <= S_STORE;
          end
        end
        S_STORE: if (mem_ack) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign mem_req   = (state == S_LOAD) || (state == S_STORE);
  assign mem_we    = (state == S_STORE);
  assign mem_addr  = addr_q;
  assign mem_size  = sz_q;
  assign mem_wdata = wdat_q;
  assign result    = res_q;
  assign flags_out = flg_out_q;
  assign done      = done_q;
  assign undef_op  = ud_q;

endmodule

module bit_test_unit_chk #(
  parameter int AW = 32,
  parameter int FLAG_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              undef_op,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [AW-1:0]     mem_addr,
  input logic [FLAG_W-1:0] flags_out,
  input logic [FLAG_W-1:0] flg_q
);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_store_same_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !$past(mem_we) |-> $past(mem_req) && mem_addr == $past(mem_addr));

  p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_undef_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    undef_op |-> done && !mem_req);

  p_other_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !undef_op |-> flags_out[FLAG_W-1:1] == flg_q[FLAG_W-1:1]);

endmodule

bind bit_test_unit bit_test_unit_chk #(.AW(AW), .FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .undef_op(undef_op),
  .req_ready(req_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .flags_out(flags_out), .flg_q(flg_q)
);

// File: tb/bit_test_unit_tb.sv
module bit_test_unit_tb;
  localparam int AW = 32;
  localparam int FW = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [7:0] opc = 0;
  logic [2:0] modrm_reg = 0;
  logic [1:0] size_sel = 0;
  logic use_mem = 0;
  logic [63:0] opnd_reg = 0, idx_reg = 0;
  logic [5:0] imm_idx = 0;
  logic [AW-1:0] base_addr = 0;
  logic [FW-1:0] flags_in = 0, flags_out;
  logic [63:0] result, mem_wdata, mem_rdata;
  logic done, undef_op, mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [AW-1:0] last_raddr = 0, last_waddr = 0;
  logic [63:0] last_wdata = 0;

  always #2.5 clk = ~clk;

  bit_test_unit #(.AW(AW), .FLAG_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .opc(opc), .modrm_reg(modrm_reg), .size_sel(size_sel), .use_mem(use_mem),
    .opnd_reg(opnd_reg), .idx_reg(idx_reg), .imm_idx(imm_idx),
    .base_addr(base_addr), .flags_in(flags_in), .flags_out(flags_out),
    .result(result), .done(done), .undef_op(undef_op), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  assign mem_rdata = {mem_addr, ~mem_addr};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack) begin
        if (mem_we) begin wr_cnt <= wr_cnt + 1; last_waddr <= mem_addr; last_wdata <= mem_wdata; end
        else begin rd_cnt <= rd_cnt + 1; last_raddr <= mem_addr; end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int f_w(input int s);
    return (s == 0) ? 16 : ((s == 1) ? 32 : 64);
  endfunction

  function automatic logic [63:0] f_wm(input int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] f_res(input int op, input int w, input logic [63:0] v, input int p);
    logic [63:0] m, b, x;
    m = f_wm(w);
    b = 64'd1 << p;
    x = v & m;
    case (op)
      0: return x;
      1: return (x | b) & m;
      2: return (x & ~b) & m;
      default: return (x ^ b) & m;
    endcase
  endfunction

  function automatic logic [AW-1:0] f_addr(input logic [AW-1:0] b, input logic [63:0] idx, input int s);
    logic signed [63:0] off, word;
    int w;
    w = f_w(s);
    if (w == 16) off = {{48{idx[15]}}, idx[15:0]};
    else if (w == 32) off = {{32{idx[31]}}, idx[31:0]};
    else off = idx;
    word = off / w;
    if (off < 0 && (off % w) != 0) word = word - 1;
    return b + AW'(word * (w / 8));
  endfunction

  task automatic do_op(input logic [7:0] o, input logic [2:0] rg, input int s, input bit m,
                       input logic [63:0] opnd, input logic [63:0] idx, input logic [5:0] imm,
                       input logic [AW-1:0] b, input logic [FW-1:0] fl, output int lat, output bit ud);
    @(negedge clk);
    opc = o; modrm_reg = rg; size_sel = 2'(s); use_mem = m; opnd_reg = opnd;
    idx_reg = idx; imm_idx = imm; base_addr = b; flags_in = fl; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    ud = undef_op;
    if (!done) check(0, "watchdog op", 0, 1);
  endtask

  task automatic t_reset();
    check(req_ready === 1'b1, "R1 ready", 64'(req_ready), 1);
    check(done === 1'b0 && undef_op === 1'b0, "R1 done/ud", 64'({done, undef_op}), 0);
    check(mem_req === 1'b0, "R1 mem_req", 64'(mem_req), 0);
    check(flags_out === '0 && result === '0, "R1 outputs", result, 0);
  endtask

  task automatic t_reg_forms();
    logic [7:0] ops[4] = '{8'hA3, 8'hAB, 8'hB3, 8'hBB};
    logic [63:0] pats[3] = '{64'hDEAD_BEEF_0123_4567, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
    for (int s = 0; s < 3; s++)
      for (int k = 0; k < 4; k++)
        for (int q = 0; q < 3; q++) begin
          int lat, w, p; bit ud; logic [63:0] idx, er;
          w = f_w(s);
          idx = 64'(70 + 9 * q + k);
          p = int'(idx) % w;
          do_op(ops[k], 3'd0, s, 0, pats[q], idx, 6'd0, 0, 8'hA6, lat, ud);
          er = f_res(k, w, pats[q], p);
          check(result == er, $sformatf("R3 R4 R6 reg op%0d w%0d", k, w), result, er);
          check(flags_out[0] == pats[q][p], "R2 carry reg", 64'(flags_out[0]), 64'(pats[q][p]));
          check(flags_out[7:1] == 7'h53, "R10 other flags", 64'(flags_out), 64'hA6);
          check(lat == 2 && !ud, "R9 reg latency", 64'(lat), 2);
        end
  endtask

  task automatic t_imm_forms();
    for (int r = 4; r < 8; r++)
      for (int s = 0; s < 3; s++) begin
        int lat, w, p; bit ud; logic [63:0] v, er; int rd0;
        w = f_w(s);
        v = 64'h8421_7BDE_F00F_5AA5 ^ 64'(r * 1234567);
        p = (37 + r) % w;
        rd0 = rd_cnt;
        do_op(8'hBA, 3'(r), s, 0, v, 64'hFFFF, 6'(37 + r), 0, 8'h01, lat, ud);
        er = f_res(r - 4, w, v, p);
        check(result == er && !ud, $sformatf("R5 R6 imm reg%0d w%0d", r, w), result, er);
        check(flags_out[0] == v[p] && flags_out[7:1] == 0, "R2 R10 imm flags", 64'(flags_out), 64'(v[p]));
        check(rd_cnt == rd0, "R8 no mem on reg form", 64'(rd_cnt - rd0), 0);
      end
  endtask

  task automatic t_undef();
    logic [7:0] bad_op[5] = '{8'hBA, 8'hBA, 8'hBA, 8'hBA, 8'h12};
    for (int i = 0; i < 5; i++) begin
      int lat, rd0, wr0; bit ud; logic [63:0] r0;
      rd0 = rd_cnt; wr0 = wr_cnt; r0 = result;
      do_op(bad_op[i], 3'(i), 2, 1, 64'h1, 64'd3, 6'd0, 32'h100, 8'h5A, lat, ud);
      check(ud && lat == 1, $sformatf("R5 undef %0d", i), 64'({ud, 8'(lat)}), 64'h101);
      check(flags_out == 8'h5A, "R5 flags passed through", 64'(flags_out), 64'h5A);
      check(rd_cnt == rd0 && wr_cnt == wr0 && result == r0, "R5 no access", 64'(rd_cnt - rd0), 0);
    end
  endtask

  task automatic t_mem();
    logic [63:0] offs[4] = '{64'd5, 64'd77, -64'sd3, -64'sd200};
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 3; s++)
        for (int j = 0; j < 4; j++) begin
          int lat, w, p, rd0, wr0; bit ud; logic [AW-1:0] ea; logic [63:0] ld, er;
          logic [7:0] ops[4] = '{8'hA3, 8'hAB, 8'hB3, 8'hBB};
          w = f_w(s);
          ea = f_addr(32'h0000_4000, offs[j], s);
          p = int'(offs[j] & 64'(w - 1));
          ld = {ea, ~ea} & f_wm(w);
          er = f_res(k, w, ld, p);
          rd0 = rd_cnt; wr0 = wr_cnt;
          do_op(ops[k], 3'd0, s, 1, 64'h0, offs[j], 6'd0, 32'h0000_4000, 8'hF0, lat, ud);
          check(last_raddr == ea && rd_cnt == rd0 + 1, $sformatf("R7 load addr op%0d w%0d off%0d", k, w, j), 64'(last_raddr), 64'(ea));
          check(flags_out == {7'h78, ld[p]}, "R2 R10 mem carry", 64'(flags_out), 64'({7'h78, ld[p]}));
          check(result == er, "R3 mem result", result, er);
          if (k == 0) begin
            check(wr_cnt == wr0, "R8 test no store", 64'(wr_cnt - wr0), 0);
            check(lat == 3, "R9 mem test latency", 64'(lat), 3);
          end else begin
            check(wr_cnt == wr0 + 1 && last_waddr == ea, "R8 store addr", 64'(last_waddr), 64'(ea));
            check(last_wdata == er, "R8 store data", last_wdata, er);
            check(lat == 5, "R9 mem modify latency", 64'(lat), 5);
          end
        end
    begin
      int lat; bit ud; logic [63:0] ld, er;
      ld = {32'h300, ~32'h300} & f_wm(32);
      er = f_res(3, 32, ld, 9);
      do_op(8'hBA, 3'd7, 1, 1, 64'h0, 64'hFFFF_FFFF, 6'd41, 32'h300, 8'h00, lat, ud);
      check(last_waddr == 32'h300 && last_wdata == er, "R7 imm mem uses base", last_wdata, er);
    end
  endtask

  task automatic t_busy();
    int rd0, wr0, n; logic [AW-1:0] ea; logic [63:0] er;
    rd0 = rd_cnt; wr0 = wr_cnt;
    ea = f_addr(32'h800, 64'd100, 2);
    er = f_res(1, 64, {ea, ~ea}, 36);
    @(negedge clk);
    opc = 8'hAB; modrm_reg = 0; size_sel = 2; use_mem = 1; idx_reg = 64'd100;
    base_addr = 32'h800; flags_in = 0; req_valid = 1;
    @(negedge clk);
    check(req_ready == 0, "R11 busy not ready", 64'(req_ready), 0);
    opc = 8'hB3; base_addr = 32'h9000; idx_reg = 64'd1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 3;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(wr_cnt == wr0 + 1 && rd_cnt == rd0 + 1, "R11 single access", 64'(wr_cnt - wr0), 1);
    check(last_waddr == ea && last_wdata == er, "R11 first request kept", last_wdata, er);
    for (int i = 0; i < 4; i++) @(negedge clk);
    check(rd_cnt == rd0 + 1 && !done, "R11 busy request dropped", 64'(rd_cnt - rd0), 1);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_reg_forms();
    t_imm_forms();
    t_undef();
    t_mem();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule